// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block gathers interrupt events from three subsystems that sit around it: an analog-to-digital converter, a bank of general-purpose inputs and a set of DAC output drivers. Each event is held in a sticky flag bit of a six-bit flag word, and the masked OR of those bits drives a single active-high interrupt line. For each of the three families, a twelve-port status register records which port raised the event. A host reads this status in two halves: ports 0 to 10 in the low half and port 11 in the high half.

Two clearing rules apply. The conversion-complete flag and the data-missed flag drop on a single read of the flag word. The data-ready, input-event, input-missed and overcurrent flags need a two-step clear: the host first reads the flag word, and then reads both status halves of the related family. Per-port sample averaging is applied before the data-ready logic. A port set to average 2^N samples refreshes its data register, and so raises data-ready, only on every 2^N-th sample.

The host accesses the block through a plain strobe-and-address read port with registered read data. A write strobe at one address loads the interrupt mask.

Top module: `irq_status_hub`

## Requirements
- R1: The flag word holds conversion-complete in bit 0, ADC data-ready in bit 1, ADC data-missed in bit 2, input-event in bit 3, input-missed in bit 4 and overcurrent in bit 5. Bits 15:6 read as zero, and after reset every flag is 0.
- R2: The ADC mode input is encoded as 0 idle, 1 single conversion, 2 single sweep and 3 continuous sweep. Bit 0 sets on a conversion-done pulse in mode 1. It sets on a sweep-done pulse in mode 2 or 3. No other pulse/mode pairing sets it.
- R3: While the ADC mode is idle (0), neither done pulse sets bit 0.
- R4: A port whose averaging exponent field (3 bits per port, port p at bits 3p+2:3p) holds N refreshes on every 2^N-th sample pulse. Each refresh sets bit 1 and that port's bit in the ADC status register.
- R5: A refresh of a port whose previous refresh has not been followed by a data-read pulse for that port sets bit 2. A refresh that follows such a read does not set it.
- R6: A read of the flag word (address 0) returns the flags as they were before the read, and clears bits 0 and 2.
- R7: Bits 1, 3, 4 and 5 clear only when a flag-word read is followed by reads of both halves of the related family, in either order. Half reads without a prior flag-word read leave the flag set. A new flag-word read restarts the sequence.
- R8: An input event sets bit 3 and the port's input status bit. An event on a port whose input status bit is still set and is not being cleared in that cycle also sets bit 4.
- R9: An overcurrent pulse on any port sets bit 5 and that port's bit in the overcurrent status register.
- R10: Addresses 1/2 (ADC), 3/4 (input) and 5/6 (overcurrent) read the low half (ports 10:0 in bits 10:0) and the high half (port 11 in bit 0). Each read clears the half it returns.
- R11: An event arriving in the same cycle as a read that would clear its flag or status bit wins, and the bit stays set.
- R12: The interrupt output is the OR of the flag bits ANDed with a six-bit mask. The mask is written at address 7 through bits 5:0 of the write data, reads back at address 7, and resets to all ones.
- R13: Read data appears on the output one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_mode | input | 2 | ADC operating mode (0 idle, 1 single conversion, 2 single sweep, 3 continuous sweep) |
| adc_conv_done | input | 1 | Pulse: single conversion finished |
| adc_sweep_done | input | 1 | Pulse: sweep finished |
| adc_sample | input | 12 | Per-port pulse: new raw sample taken |
| adc_avg_exp | input | 36 | Per-port averaging exponent, 3 bits per port |
| adc_data_rd | input | 12 | Per-port pulse: host read that port's data register |
| gpi_event | input | 12 | Per-port pulse: selected input event captured |
| dac_oc | input | 12 | Per-port pulse: driver overcurrent |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 6 | Write data (mask) |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: twelve ports and a three-bit averaging exponent. With these values the high status half carries exactly one port (port 11), and averaging exponents up to 7 are available. The bench programs exponent 2 on one port, so the four-sample refresh boundary is reached within a few pulses. The twelve-port default also lets the bench check half-read clearing across the low/high boundary by firing ports 5 and 11 together.

// File: rtl/irq_hub_pkg.sv
// Package: shared address map, flag positions and ADC mode encoding for
// the sticky interrupt status register.
package irq_hub_pkg;

    localparam int DATA_W = 16;
    localparam int NFLAGS = 6;

    // Flag word bit positions
    localparam int F_ADC_DONE = 0;
    localparam int F_ADC_RDY  = 1;
    localparam int F_ADC_MISS = 2;
    localparam int F_GPI_RDY  = 3;
    localparam int F_GPI_MISS = 4;
    localparam int F_DAC_OC   = 5;

    // Register addresses
    localparam logic [2:0] A_FLAGS  = 3'd0;
    localparam logic [2:0] A_ADC_LO = 3'd1;
    localparam logic [2:0] A_ADC_HI = 3'd2;
    localparam logic [2:0] A_GPI_LO = 3'd3;
    localparam logic [2:0] A_GPI_HI = 3'd4;
    localparam logic [2:0] A_DAC_LO = 3'd5;
    localparam logic [2:0] A_DAC_HI = 3'd6;
    localparam logic [2:0] A_MASK   = 3'd7;

    typedef enum logic [1:0] {
        ADC_IDLE         = 2'd0,
        ADC_SINGLE_CONV  = 2'd1,
        ADC_SINGLE_SWEEP = 2'd2,
        ADC_CONT_SWEEP   = 2'd3
    } adc_mode_e;

endpackage

// File: rtl/avg_divider.sv
// Module: avg_divider
// Divides one port's sample pulses by 2^exp. It emits a refresh on the
// sample that completes an averaging window.
// Assumes exp may change at any time. A count already past the new limit
// refreshes on the next sample.
module avg_divider #(
    parameter int AVG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [AVG_W-1:0] exp_sel,
    output logic             refresh
);
    localparam int CNT_W = (1 << AVG_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Last count value of the window: 2^exp - 1
    assign limit   = (CNT_W'(1) << exp_sel) - CNT_W'(1);
    assign refresh = sample && (cnt_q >= limit);

    // Count samples inside the current window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sample) begin
            cnt_q <= refresh ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R4: without averaging, every sample refreshes
    p_no_avg_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && exp_sel == '0) |-> refresh);

endmodule

// File: rtl/port_status_bank.sv
// Module: port_status_bank
// Per-port sticky status bits. An event sets its bit and a clear mask
// drops bits, with events taking priority. Also reports an overwrite:
// an event landing on a bit that is still set and not being cleared.
module port_status_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status,
    output logic         overwrite
);
    logic [N-1:0] status_q;

    assign status    = status_q;
    assign overwrite = |(evt & status_q & ~clr);

    // Clear requested bits, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | evt;
        end
    end

    // R11: an event always lands, even under a same-cycle clear
    p_evt_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/two_step_clear.sv
// Module: two_step_clear
// Sticky flags that clear only after a flag-word read (arm) followed by
// reads of both status halves, in either order. A new arm restarts the
// half-read tracking. A set in the clearing cycle keeps its flag.
module two_step_clear #(
    parameter int NF = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic          arm_rd,
    input  logic          lo_rd,
    input  logic          hi_rd,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] flags_q;
    logic          arm_q;
    logic          lo_q;
    logic          hi_q;
    logic          done;

    assign flags = flags_q;
    assign done  = arm_q && (lo_q || lo_rd) && (hi_q || hi_rd);

    // Flag storage: drop on completed sequence, new sets win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (done ? '0 : flags_q) | set;
        end
    end

    // Sequence tracking: arm, then record each half read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            lo_q  <= 1'b0;
            hi_q  <= 1'b0;
        end else if (done) begin
            arm_q <= 1'b0;
            lo_q  <= 1'b0;
            hi_q  <= 1'b0;
        end else if (arm_rd) begin
            arm_q <= 1'b1;
            lo_q  <= 1'b0;
            hi_q  <= 1'b0;
        end else begin
            if (arm_q && lo_rd) lo_q <= 1'b1;
            if (arm_q && hi_rd) hi_q <= 1'b1;
        end
    end

    // R7: with no arm in place, set flags cannot drop
    p_hold_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && flags_q != '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R11: a set always shows up on the next cycle
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags_q & $past(set)) == $past(set)));

endmodule

// File: rtl/irq_status_hub.sv
// Module: irq_status_hub (top)
// Sticky interrupt flag word with per-family port status, a masked
// interrupt output and a strobe/address read port with registered data.
// Assumes all event inputs are single-cycle pulses synchronous to clk.
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int NPORT = 12,
    parameter int AVG_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             adc_mode,
    input  logic                   adc_conv_done,
    input  logic                   adc_sweep_done,
    input  logic [NPORT-1:0]       adc_sample,
    input  logic [NPORT*AVG_W-1:0] adc_avg_exp,
    input  logic [NPORT-1:0]       adc_data_rd,
    input  logic [NPORT-1:0]       gpi_event,
    input  logic [NPORT-1:0]       dac_oc,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic [2:0]             host_addr,
    input  logic [NFLAGS-1:0]      host_wdata,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   irq
);
    localparam int LO_W = NPORT - 1;

    adc_mode_e          mode;
    logic               rd_flags;
    logic               rd_adc_lo, rd_adc_hi;
    logic               rd_gpi_lo, rd_gpi_hi;
    logic               rd_dac_lo, rd_dac_hi;
    logic               adc_done_set;
    logic [NPORT-1:0]   adc_refresh;
    logic [NPORT-1:0]   adc_st, gpi_st, dac_st, unread_st;
    logic               adc_ovw_unused, dac_ovw_unused, unread_st_unused;
    logic               adc_miss_set, gpi_miss_set;
    logic               flag_done_q, flag_miss_q;
    logic [0:0]         adc_rdy;
    logic [1:0]         gpi_flags;
    logic [0:0]         dac_flag;
    logic [NFLAGS-1:0]  flags;
    logic [NFLAGS-1:0]  mask_q;
    logic [DATA_W-1:0]  rd_data_q;

    assign mode      = adc_mode_e'(adc_mode);
    assign rd_flags  = host_rd && host_addr == A_FLAGS;
    assign rd_adc_lo = host_rd && host_addr == A_ADC_LO;
    assign rd_adc_hi = host_rd && host_addr == A_ADC_HI;
    assign rd_gpi_lo = host_rd && host_addr == A_GPI_LO;
    assign rd_gpi_hi = host_rd && host_addr == A_GPI_HI;
    assign rd_dac_lo = host_rd && host_addr == A_DAC_LO;
    assign rd_dac_hi = host_rd && host_addr == A_DAC_HI;

    // Completion event qualified by the ADC mode
    assign adc_done_set = (mode == ADC_SINGLE_CONV && adc_conv_done) ||
                          ((mode == ADC_SINGLE_SWEEP || mode == ADC_CONT_SWEEP) && adc_sweep_done);

    // One averaging divider per port
    for (genvar p = 0; p < NPORT; p++) begin : g_avg
        avg_divider #(.AVG_W(AVG_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample  (adc_sample[p]),
            .exp_sel (adc_avg_exp[p*AVG_W +: AVG_W]),
            .refresh (adc_refresh[p])
        );
    end

    // Per-port status registers, cleared half by half on reads
    port_status_bank #(.N(NPORT)) u_adc_st (
        .clk(clk), .rst_n(rst_n), .evt(adc_refresh),
        .clr({rd_adc_hi, {LO_W{rd_adc_lo}}}),
        .status(adc_st), .overwrite(adc_ovw_unused));

    port_status_bank #(.N(NPORT)) u_gpi_st (
        .clk(clk), .rst_n(rst_n), .evt(gpi_event),
        .clr({rd_gpi_hi, {LO_W{rd_gpi_lo}}}),
        .status(gpi_st), .overwrite(gpi_miss_set));

    port_status_bank #(.N(NPORT)) u_dac_st (
        .clk(clk), .rst_n(rst_n), .evt(dac_oc),
        .clr({rd_dac_hi, {LO_W{rd_dac_lo}}}),
        .status(dac_st), .overwrite(dac_ovw_unused));

    // Unread-data tracker: detects ADC data overwritten before its read
    port_status_bank #(.N(NPORT)) u_unread (
        .clk(clk), .rst_n(rst_n), .evt(adc_refresh), .clr(adc_data_rd),
        .status(unread_st), .overwrite(adc_miss_set));

    assign unread_st_unused = |unread_st;

    // Two-step-clear flag groups
    two_step_clear #(.NF(1)) u_adc_rdy (
        .clk(clk), .rst_n(rst_n), .set(|adc_refresh),
        .arm_rd(rd_flags), .lo_rd(rd_adc_lo), .hi_rd(rd_adc_hi), .flags(adc_rdy));

    two_step_clear #(.NF(2)) u_gpi (
        .clk(clk), .rst_n(rst_n), .set({gpi_miss_set, |gpi_event}),
        .arm_rd(rd_flags), .lo_rd(rd_gpi_lo), .hi_rd(rd_gpi_hi), .flags(gpi_flags));

    two_step_clear #(.NF(1)) u_dac (
        .clk(clk), .rst_n(rst_n), .set(|dac_oc),
        .arm_rd(rd_flags), .lo_rd(rd_dac_lo), .hi_rd(rd_dac_hi), .flags(dac_flag));

    // Single-read-clear flags; a same-cycle event keeps the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_done_q <= 1'b0;
            flag_miss_q <= 1'b0;
        end else begin
            flag_done_q <= (flag_done_q && !rd_flags) || adc_done_set;
            flag_miss_q <= (flag_miss_q && !rd_flags) || adc_miss_set;
        end
    end

    assign flags = {dac_flag[0], gpi_flags[1], gpi_flags[0],
                    flag_miss_q, adc_rdy[0], flag_done_q};

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (host_wr && host_addr == A_MASK) begin
            mask_q <= host_wdata;
        end
    end

    assign irq = |(flags & mask_q);

    // Registered read data multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (host_rd) begin
            case (host_addr)
                A_FLAGS:  rd_data_q <= {{(DATA_W-NFLAGS){1'b0}}, flags};
                A_ADC_LO: rd_data_q <= {{(DATA_W-LO_W){1'b0}}, adc_st[LO_W-1:0]};
                A_ADC_HI: rd_data_q <= {{(DATA_W-1){1'b0}}, adc_st[NPORT-1]};
                A_GPI_LO: rd_data_q <= {{(DATA_W-LO_W){1'b0}}, gpi_st[LO_W-1:0]};
                A_GPI_HI: rd_data_q <= {{(DATA_W-1){1'b0}}, gpi_st[NPORT-1]};
                A_DAC_LO: rd_data_q <= {{(DATA_W-LO_W){1'b0}}, dac_st[LO_W-1:0]};
                A_DAC_HI: rd_data_q <= {{(DATA_W-1){1'b0}}, dac_st[NPORT-1]};
                default:  rd_data_q <= {{(DATA_W-NFLAGS){1'b0}}, mask_q};
            endcase
        end
    end

    assign rd_data = rd_data_q;

    // R3: idle mode never raises the completion flag
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ADC_IDLE && !flag_done_q) |=> !flag_done_q);

    // R1: upper bits of a flag-word read are zero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == A_FLAGS) |=> (rd_data[DATA_W-1:NFLAGS] == '0));

    // R6: a flag-word read with no new completion leaves bit 0 clear
    p_single_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !adc_done_set) |=> !flag_done_q);

    // R13: read data holds while no read is strobed
    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd) |=> $stable(rd_data));

endmodule

// File: tb/tb_irq_status_hub.sv
module tb_irq_status_hub;
    import irq_hub_pkg::*;

    localparam int NPORT = 12;
    localparam int AVG_W = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [1:0]             adc_mode = '0;
    logic                   adc_conv_done = 1'b0;
    logic                   adc_sweep_done = 1'b0;
    logic [NPORT-1:0]       adc_sample = '0;
    logic [NPORT*AVG_W-1:0] adc_avg_exp = '0;
    logic [NPORT-1:0]       adc_data_rd = '0;
    logic [NPORT-1:0]       gpi_event = '0;
    logic [NPORT-1:0]       dac_oc = '0;
    logic                   host_rd = 1'b0;
    logic                   host_wr = 1'b0;
    logic [2:0]             host_addr = '0;
    logic [NFLAGS-1:0]      host_wdata = '0;
    logic [DATA_W-1:0]      rd_data;
    logic                   irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] d;

    always #5 clk = ~clk;

    irq_status_hub #(.NPORT(NPORT), .AVG_W(AVG_W)) dut (.*);

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        adc_mode = '0; adc_avg_exp = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic wr_mask(input logic [5:0] m);
        @(negedge clk);
        host_wr = 1'b1; host_addr = A_MASK; host_wdata = m;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic race_rd(input logic [2:0] a, input logic [NPORT-1:0] g,
                           input logic conv, output logic [15:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a; gpi_event = g; adc_conv_done = conv;
        @(negedge clk);
        host_rd = 1'b0; gpi_event = '0; adc_conv_done = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse_sample(input logic [NPORT-1:0] m);
        @(negedge clk); adc_sample = m; @(negedge clk); adc_sample = '0;
    endtask
    task automatic pulse_gpi(input logic [NPORT-1:0] m);
        @(negedge clk); gpi_event = m; @(negedge clk); gpi_event = '0;
    endtask
    task automatic pulse_dac(input logic [NPORT-1:0] m);
        @(negedge clk); dac_oc = m; @(negedge clk); dac_oc = '0;
    endtask
    task automatic pulse_data_rd(input logic [NPORT-1:0] m);
        @(negedge clk); adc_data_rd = m; @(negedge clk); adc_data_rd = '0;
    endtask
    task automatic pulse_conv();
        @(negedge clk); adc_conv_done = 1'b1; @(negedge clk); adc_conv_done = 1'b0;
    endtask
    task automatic pulse_sweep();
        @(negedge clk); adc_sweep_done = 1'b1; @(negedge clk); adc_sweep_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk({15'd0, irq}, 16'h0, "R12 irq low after reset");
        rd(A_FLAGS, d);  chk(d, 16'h0000, "R1 flags zero after reset");
        rd(A_MASK, d);   chk(d, 16'h003F, "R12 mask resets to all ones");
        @(negedge clk);
        host_rd = 1'b1; host_addr = A_FLAGS;
        #1 chk(rd_data, 16'h003F, "R13 data not yet updated at strobe");
        @(negedge clk);
        host_rd = 1'b0;
        chk(rd_data, 16'h0000, "R13 data updated one clock later");
        repeat (3) @(negedge clk);
        chk(rd_data, 16'h0000, "R13 data holds without strobe");
    endtask

    task automatic t_adc_done();
        do_reset();
        adc_mode = 2'd0;
        pulse_conv(); pulse_sweep();
        rd(A_FLAGS, d); chk(d, 16'h0000, "R3 idle ignores done pulses");
        adc_mode = 2'd1;
        pulse_sweep();
        rd(A_FLAGS, d); chk(d, 16'h0000, "R2 sweep pulse ignored in single conversion");
        pulse_conv();
        rd(A_FLAGS, d); chk(d, 16'h0001, "R2 conversion done sets bit 0");
        rd(A_FLAGS, d); chk(d, 16'h0000, "R6 bit 0 cleared by one read");
        adc_mode = 2'd2;
        pulse_conv();
        rd(A_FLAGS, d); chk(d, 16'h0000, "R2 conversion pulse ignored in single sweep");
        pulse_sweep();
        rd(A_FLAGS, d); chk(d, 16'h0001, "R2 single sweep done sets bit 0");
        adc_mode = 2'd3;
        pulse_sweep();
        rd(A_FLAGS, d); chk(d, 16'h0001, "R2 continuous sweep done sets bit 0");
    endtask

    task automatic t_avg();
        do_reset();
        adc_avg_exp[2*AVG_W +: AVG_W] = 3'd2;
        for (int i = 0; i < 3; i++) pulse_sample(12'h004);
        rd(A_FLAGS, d); chk(d, 16'h0000, "R4 no refresh before 4th sample");
        pulse_sample(12'h004);
        rd(A_FLAGS, d); chk(d, 16'h0002, "R4 4th sample raises data-ready");
        rd(A_ADC_LO, d); chk(d, 16'h0004, "R4 port 2 status bit set");
        adc_avg_exp = '0;
    endtask

    task automatic t_missed();
        do_reset();
        pulse_sample(12'h001);
        pulse_data_rd(12'h001);
        pulse_sample(12'h001);
        rd(A_FLAGS, d); chk(d, 16'h0002, "R5 read between refreshes avoids miss");
        pulse_sample(12'h001);
        rd(A_FLAGS, d); chk(d, 16'h0006, "R5 unread overwrite sets bit 2");
        rd(A_FLAGS, d); chk(d, 16'h0002, "R6 bit 2 cleared by one read");
    endtask

    task automatic t_two_step();
        do_reset();
        pulse_sample(12'h800);
        rd(A_ADC_LO, d); chk(d, 16'h0000, "R10 low half excludes port 11");
        rd(A_ADC_HI, d); chk(d, 16'h0001, "R10 high half bit 0 is port 11");
        chk({15'd0, irq}, 16'h1, "R7 halves without arm keep flag");
        rd(A_FLAGS, d); chk(d, 16'h0002, "R7 data-ready still set");
        rd(A_ADC_HI, d); chk(d, 16'h0000, "R10 high half cleared by prior read");
        chk({15'd0, irq}, 16'h1, "R7 one half read keeps flag");
        rd(A_ADC_LO, d);
        chk({15'd0, irq}, 16'h0, "R7 both halves after arm clear flag");
        rd(A_FLAGS, d); chk(d, 16'h0000, "R7 flag word clear");
    endtask

    task automatic t_gpi();
        do_reset();
        pulse_gpi(12'h008);
        rd(A_FLAGS, d); chk(d, 16'h0008, "R8 event sets bit 3");
        pulse_gpi(12'h008);
        rd(A_FLAGS, d); chk(d, 16'h0018, "R8 unread status overwrite sets bit 4");
        rd(A_GPI_LO, d); chk(d, 16'h0008, "R10 input low half shows port 3");
        rd(A_GPI_HI, d); chk(d, 16'h0000, "R10 input high half empty");
        rd(A_FLAGS, d); chk(d, 16'h0000, "R7 bits 3 and 4 cleared by sequence");
        pulse_gpi(12'h008);
        rd(A_GPI_LO, d);
        pulse_gpi(12'h008);
        rd(A_FLAGS, d); chk(d, 16'h0008, "R8 event after status read is no miss");
    endtask

    task automatic t_dac();
        do_reset();
        pulse_dac(12'h820);
        rd(A_FLAGS, d);  chk(d, 16'h0020, "R9 overcurrent sets bit 5");
        rd(A_DAC_LO, d); chk(d, 16'h0020, "R9 low half records port 5");
        rd(A_DAC_HI, d); chk(d, 16'h0001, "R9 high half records port 11");
        rd(A_DAC_LO, d); chk(d, 16'h0000, "R10 low half cleared by read");
        rd(A_FLAGS, d);  chk(d, 16'h0000, "R7 bit 5 cleared by sequence");
    endtask

    task automatic t_race();
        do_reset();
        pulse_gpi(12'h002);
        rd(A_FLAGS, d);  chk(d, 16'h0008, "R8 bit 3 set");
        rd(A_GPI_LO, d); chk(d, 16'h0002, "R10 port 1 in low half");
        race_rd(A_GPI_HI, 12'h002, 1'b0, d);
        chk({15'd0, irq}, 16'h1, "R11 event wins over completing half read");
        race_rd(A_GPI_LO, 12'h004, 1'b0, d);
        chk(d, 16'h0002, "R11 read returns old low half");
        rd(A_GPI_LO, d); chk(d, 16'h0004, "R11 status event survives clearing read");
        adc_mode = 2'd1;
        race_rd(A_FLAGS, '0, 1'b1, d);
        rd(A_FLAGS, d); chk(d & 16'h0001, 16'h0001, "R11 completion wins over flag read");
    endtask

    task automatic t_mask();
        do_reset();
        wr_mask(6'h20);
        pulse_gpi(12'h001);
        chk({15'd0, irq}, 16'h0, "R12 masked flag keeps irq low");
        rd(A_MASK, d); chk(d, 16'h0020, "R12 mask readback");
        wr_mask(6'h08);
        chk({15'd0, irq}, 16'h1, "R12 unmasked flag raises irq");
        rd(A_FLAGS, d); chk(d, 16'h0008, "R1 flag word unaffected by mask");
    endtask

    initial begin
        t_reset();
        t_adc_done();
        t_avg();
        t_missed();
        t_two_step();
        t_gpi();
        t_dac();
        t_race();
        t_mask();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule